// File: doc/BRIEF.md
# Nibble Rotate Memory Unit

This block carries out the two decimal-digit rotate operations that link an 8-bit accumulator with one byte held in memory. Three 4-bit groups move in a circle: the low half of the accumulator, and the two halves of the memory byte. The instruction decoder and the address path sit outside the block. The decoder pulses `start_i`, selects the direction with `left_i`, and supplies the pointer, the current accumulator and the current flag byte.

A short sequencer drives the memory port. It issues a read and holds the request until ready, then computes for one cycle. It then issues a write of the new byte to the same address and holds that request until ready. When the write completes it updates the accumulator and flag outputs and pulses `done_o` for one cycle. The upper accumulator nibble and the carry flag pass through unchanged.

Top module: `nib_rot_unit`

## Requirements
- R1: With `left_i`=1, the byte written back is {old memory low nibble, old accumulator low nibble} (memory bits 7:4 then 3:0).
- R2: With `left_i`=1, the accumulator low nibble becomes the old memory high nibble.
- R3: With `left_i`=0, the byte written back is {old accumulator low nibble, old memory high nibble}.
- R4: With `left_i`=0, the accumulator low nibble becomes the old memory low nibble.
- R5: Bits 7:4 of `acc_o` equal bits 7:4 of the accumulator taken at start, in both directions.
- R6: Flag bit 7 (sign) equals bit 7 of the final accumulator. Flag bit 6 (zero) is 1 exactly when the final accumulator is 0.
- R7: Flag bit 2 (parity/overflow) is 1 when the final accumulator holds an even number of one bits, and 0 otherwise.
- R8: Flag bit 4 (half-carry) and flag bit 1 (subtract) are cleared. Flag bits 5 and 3 are copied from `flags_i`.
- R9: Flag bit 0 (carry) is copied unchanged from `flags_i`.
- R10: The block raises a read request, with `mem_we_o`=0, until `mem_ready_i`. After one compute cycle it raises a write request, with `mem_we_o`=1, at the same address until `mem_ready_i`. In the next cycle `done_o` is high for exactly one cycle.
- R11: A `start_i` that arrives while `busy_o` is high is ignored. The pointer, operands and direction of the operation in progress are kept.
- R12: After reset, `acc_o` and `flags_o` are 0 and `busy_o` and `done_o` are low. `acc_o` and `flags_o` change only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| left_i | input | 1 | 1: left rotate, 0: right rotate |
| ptr_i | input | ADDR_W | Address of the memory byte |
| acc_i | input | 8 | Accumulator value before the operation |
| flags_i | input | 8 | Flag byte before the operation |
| mem_rdata_i | input | 8 | Read data, valid with mem_ready_i during a read |
| mem_ready_i | input | 1 | Memory has completed the current request |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_req_o | output | 1 | Memory request (read or write) |
| mem_we_o | output | 1 | Request is a write |
| acc_o | output | 8 | Updated accumulator |
| flags_o | output | 8 | Updated flag byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume a memory that eventually answers every request. They also assume that `mem_ready_i` is high only while a request is pending, and that read data is valid in the cycle ready is seen. The bench memory model raises ready for one cycle only after a request has been held for a programmed latency of zero to three cycles, and it drops ready at once after that. It is the only driver of the port. A start pulse during busy is sent with conflicting operands and a different pointer, so the kept values show up at the outputs and in the memory contents.

// File: rtl/nib_rot_pkg.sv
package nib_rot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_CALC,
    ST_WR,
    ST_DONE
  } state_e;

  localparam int FLG_C  = 0;
  localparam int FLG_N  = 1;
  localparam int FLG_PV = 2;
  localparam int FLG_X3 = 3;
  localparam int FLG_H  = 4;
  localparam int FLG_X5 = 5;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;
endpackage

// File: rtl/nib_rot_ctrl.sv
module nib_rot_ctrl
  import nib_rot_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   mem_ready_i,
  output state_e state_o,
  output logic   launch_o,
  output logic   rd_take_o,
  output logic   calc_o,
  output logic   commit_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RD;
      ST_RD:   if (mem_ready_i) state_d = ST_CALC;
      ST_CALC: state_d = ST_WR;
      ST_WR:   if (mem_ready_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign launch_o  = (state_q == ST_IDLE) && start_i;
  assign rd_take_o = (state_q == ST_RD) && mem_ready_i;
  assign calc_o    = (state_q == ST_CALC);
  assign commit_o  = (state_q == ST_WR) && mem_ready_i;

  // R10: done lasts one cycle, write only follows compute
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
  p_wr_after_calc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_WR) |-> ($past(state_q) == ST_CALC));
  p_calc_after_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CALC) |-> ($past(state_q) == ST_RD));
endmodule

// File: rtl/nib_rot_shuffle.sv
module nib_rot_shuffle #(
  parameter int NIB_W  = 4,
  localparam int DATA_W = 2 * NIB_W
) (
  input  logic              left_i,
  input  logic [NIB_W-1:0]  acc_lo_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] mem_o,
  output logic [NIB_W-1:0]  acc_lo_o
);
  logic [NIB_W-1:0] mem_hi, mem_lo;
  assign mem_hi = mem_i[DATA_W-1:NIB_W];
  assign mem_lo = mem_i[NIB_W-1:0];

  always_comb begin
    if (left_i) begin
      mem_o    = {mem_lo, acc_lo_i};
      acc_lo_o = mem_hi;
    end else begin
      mem_o    = {acc_lo_i, mem_hi};
      acc_lo_o = mem_lo;
    end
  end
endmodule

// File: rtl/nib_rot_flag_gen.sv
module nib_rot_flag_gen
  import nib_rot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [7:0]        flags_i,
  output logic [7:0]        flags_o
);
  always_comb begin
    flags_o         = flags_i;   // carry and spare bits pass through
    flags_o[FLG_S]  = acc_i[DATA_W-1];
    flags_o[FLG_Z]  = (acc_i == '0);
    flags_o[FLG_H]  = 1'b0;
    flags_o[FLG_PV] = ~^acc_i;
    flags_o[FLG_N]  = 1'b0;
  end
endmodule

// File: rtl/nib_rot_unit.sv
module nib_rot_unit
  import nib_rot_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NIB_W  = 4,
  localparam int DATA_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              left_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [7:0]        flags_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [7:0]        flags_o,
  output logic              busy_o,
  output logic              done_o
);
  state_e state;
  logic launch, rd_take, calc, commit;

  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] acc_q, rd_q, wr_q, acc_new_q;
  logic [7:0]        flg_q;
  logic              left_q;

  logic [DATA_W-1:0] mem_next;
  logic [NIB_W-1:0]  acc_lo_next;
  logic [7:0]        flags_next;

  nib_rot_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mem_ready_i(mem_ready_i),
    .state_o    (state),
    .launch_o   (launch),
    .rd_take_o  (rd_take),
    .calc_o     (calc),
    .commit_o   (commit)
  );

  nib_rot_shuffle #(.NIB_W(NIB_W)) u_shuffle (
    .left_i  (left_q),
    .acc_lo_i(acc_q[NIB_W-1:0]),
    .mem_i   (rd_q),
    .mem_o   (mem_next),
    .acc_lo_o(acc_lo_next)
  );

  nib_rot_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .acc_i  (acc_new_q),
    .flags_i(flg_q),
    .flags_o(flags_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      acc_q     <= '0;
      flg_q     <= '0;
      left_q    <= 1'b0;
      rd_q      <= '0;
      wr_q      <= '0;
      acc_new_q <= '0;
      acc_o     <= '0;
      flags_o   <= '0;
    end else begin
      if (launch) begin
        ptr_q  <= ptr_i;
        acc_q  <= acc_i;
        flg_q  <= flags_i;
        left_q <= left_i;
      end
      if (rd_take) rd_q <= mem_rdata_i;
      if (calc) begin
        wr_q      <= mem_next;
        acc_new_q <= {acc_q[DATA_W-1:NIB_W], acc_lo_next};
      end
      if (commit) begin
        acc_o   <= acc_new_q;
        flags_o <= flags_next;
      end
    end
  end

  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = wr_q;
  assign mem_req_o   = (state == ST_RD) || (state == ST_WR);
  assign mem_we_o    = (state == ST_WR);
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_DONE);

  p_acc_hi_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (acc_o[DATA_W-1:NIB_W] == acc_q[DATA_W-1:NIB_W]));
  p_carry_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[FLG_C] == flg_q[FLG_C]));
  p_hn_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!flags_o[FLG_H] && !flags_o[FLG_N]));
  p_zero_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[FLG_Z] == (acc_o == '0)));
  p_parity_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[FLG_PV] == ($countones(acc_o) % 2 == 0)));
  p_out_held_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(acc_o) && $stable(flags_o)) |-> done_o);
  p_we_in_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);
  p_done_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> ($stable(ptr_q) && $stable(acc_q) && $stable(left_q)));
endmodule

// File: tb/nib_rot_unit_bench.sv
module nib_rot_unit_bench;
  localparam int ADDR_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             left = 1'b0;
  logic [ADDR_W-1:0] ptr = '0;
  logic [7:0]       acc_in = '0;
  logic [7:0]       flg_in = '0;
  logic [7:0]       rdata;
  logic             ready = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic [7:0]       wdata;
  logic             req, we;
  logic [7:0]       acc_out, flg_out;
  logic             busy, done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lat = 0;
  int lat_cnt = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [7:0] mem [16];

  always #2 clk = ~clk;

  nib_rot_unit #(.ADDR_W(ADDR_W)) u_nib_rot_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .left_i(left),
    .ptr_i(ptr), .acc_i(acc_in), .flags_i(flg_in),
    .mem_rdata_i(rdata), .mem_ready_i(ready),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_req_o(req), .mem_we_o(we),
    .acc_o(acc_out), .flags_o(flg_out), .busy_o(busy), .done_o(done)
  );

  assign rdata = mem[addr];

  // memory model: ready after lat held cycles, one cycle wide
  always @(posedge clk) begin
    if (req && ready) begin
      if (we) begin mem[addr] <= wdata; wr_cnt <= wr_cnt + 1; end
      else rd_cnt <= rd_cnt + 1;
      ready   <= 1'b0;
      lat_cnt <= 0;
    end else if (req) begin
      if (lat_cnt >= lat) ready <= 1'b1;
      else lat_cnt <= lat_cnt + 1;
    end else begin
      ready   <= 1'b0;
      lat_cnt <= 0;
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic       l;
    logic [3:0] p;
    logic [7:0] a;
    logic [7:0] m;
    logic [7:0] f;
    logic [1:0] lt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h3, 8'h12, 8'h34, 8'h00, 2'd0},
    '{1'b0, 4'h3, 8'h12, 8'h34, 8'hFF, 2'd1},
    '{1'b1, 4'h0, 8'h0A, 8'h0B, 8'h01, 2'd2},
    '{1'b0, 4'hF, 8'hF0, 8'h70, 8'h28, 2'd3},
    '{1'b1, 4'h7, 8'h9C, 8'hE5, 8'hD6, 2'd0},
    '{1'b0, 4'h8, 8'h00, 8'hA0, 8'h01, 2'd1},
    '{1'b1, 4'h5, 8'h5F, 8'h81, 8'h00, 2'd0},
    '{1'b0, 4'h2, 8'h33, 8'hC3, 8'h10, 2'd2}
  };

  task automatic run_op(input vec_t v, input bit poke);
    logic [7:0] e_mem, e_acc, e_flg, acc0, flg0;
    bit held, seen;
    int n;
    if (v.l) begin
      e_mem = {v.m[3:0], v.a[3:0]};   // R1
      e_acc = {v.a[7:4], v.m[7:4]};   // R2
    end else begin
      e_mem = {v.a[3:0], v.m[7:4]};   // R3
      e_acc = {v.a[7:4], v.m[3:0]};   // R4
    end
    e_flg = {e_acc[7], e_acc == 8'h00, v.f[5], 1'b0, v.f[3], ~^e_acc, 1'b0, v.f[0]};
    mem[v.p] = v.m;
    mem[v.p ^ 4'h1] = 8'h5A;
    lat = int'(v.lt);
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    left = v.l; ptr = v.p; acc_in = v.a; flg_in = v.f; start = 1'b1;
    acc0 = acc_out; flg0 = flg_out;
    @(negedge clk);
    start = 1'b0;
    held = 1; seen = 0; n = 0;
    while (!seen && n < 40) begin
      if (poke && n == 1) begin
        start = 1'b1; left = ~v.l; ptr = v.p ^ 4'h1; acc_in = ~v.a; flg_in = ~v.f;
      end else start = 1'b0;
      if (done) seen = 1;
      else begin
        if (acc_out !== acc0 || flg_out !== flg0) held = 0;
        @(negedge clk);
        n++;
      end
    end
    start = 1'b0;
    chk(seen, "R10 done seen", 32'(seen), 1);
    chk(held, "R12 outputs held until done", {acc_out, flg_out}, {acc0, flg0});
    chk(acc_out[3:0] == e_acc[3:0], v.l ? "R2 acc low" : "R4 acc low", acc_out, e_acc);
    chk(acc_out[7:4] == v.a[7:4], "R5 acc high", acc_out, v.a);
    chk(mem[v.p] == e_mem, v.l ? "R1 mem byte" : "R3 mem byte", mem[v.p], e_mem);
    chk(flg_out[7:6] == e_flg[7:6], "R6 sign/zero", flg_out, e_flg);
    chk(flg_out[2] == e_flg[2], "R7 parity", flg_out, e_flg);
    chk({flg_out[5:3], flg_out[1]} == {e_flg[5:3], e_flg[1]}, "R8 H/N/spare", flg_out, e_flg);
    chk(flg_out[0] == v.f[0], "R9 carry", flg_out, v.f);
    chk(rd_cnt == 1 && wr_cnt == 1, "R10 one read one write", {rd_cnt[15:0], wr_cnt[15:0]}, 32'h00010001);
    @(negedge clk);
    chk(!done, "R10 done one cycle", 32'(done), 0);
    if (poke) begin
      chk(mem[v.p ^ 4'h1] == 8'h5A, "R11 other address untouched", mem[v.p ^ 4'h1], 8'h5A);
      chk(!busy, "R11 no second op", 32'(busy), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(acc_out == 8'h00 && flg_out == 8'h00, "R12 reset outputs", {acc_out, flg_out}, 0);
    chk(!busy && !done && !req, "R12 reset idle", {busy, done, req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0);
    // corner cases: start ignored while busy (R11)
    run_op('{1'b1, 4'h6, 8'hC7, 8'h29, 8'h81, 2'd2}, 1'b1);
    run_op('{1'b0, 4'h9, 8'h0E, 8'hD4, 8'h00, 2'd3}, 1'b1);
    // zero result, both directions (R6)
    run_op('{1'b1, 4'hA, 8'h03, 8'h0C, 8'h01, 2'd0}, 1'b0);
    run_op('{1'b0, 4'hB, 8'h07, 8'h60, 8'h00, 2'd1}, 1'b0);
    summary();
  end
endmodule